// File: doc/BRIEF.md
# Memory Protection Region Lookup

This unit decides, for each bus access, which of eight programmable protection regions covers the address, whether the access is allowed, and what memory attributes apply. Software-visible configuration is loaded through a plain write port: one full region descriptor per write, selected by an index. A lookup request carries an address, an access kind (read, write or instruction fetch) and the current privilege level. One clock later the unit returns the winning region, a fault flag, the decoded memory type, the shareability and a flag for attribute encodings that have no defined meaning.

Each region covers a naturally aligned power-of-two span. The span is cut into eight equal slices, and each slice can be removed from the region by a mask bit. An address in a removed slice is not claimed by that region, so a lower-numbered region that overlaps the same address wins instead. This lets a small region and a large region share one base address: the small region's attributes cover the low part, and the large region covers the rest.

Top module: `mpu_lookup`

## Requirements
- R1: After reset every region is disabled and the response outputs are zero. Until a region is programmed, an unprivileged lookup faults and reports no hit.
- R2: A write with `wr_valid_i` high stores every field into region `wr_idx_i` at the clock edge. A lookup issued in the same cycle as the write uses the previous contents. The next cycle's lookup uses the new contents.
- R3: `rsp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. The other response fields belong to that request.
- R4: A region with size code N spans 2^(N+1) bytes (N from 0 to 31). The low N+1 bits of its base are ignored, so the span is aligned, and an address hits when it lies in that aligned span.
- R5: The span is split into eight equal slices, with slice 0 at the lowest addresses. Bit i of the slice mask removes slice i from the hit. The mask is ignored when N < 7, which means spans below 256 bytes.
- R6: When several enabled regions hit, the highest index wins and is reported on `rsp_region_o` with `rsp_hit_o`=1. A region whose slice is masked does not take part.
- R7: Permission bits are ordered {user write, user read, privileged write, privileged read} from bit 3 down to bit 0. Access kind is encoded 0=read, 1=write, 2=fetch, 3=read. A write needs the write bit for the current level, and the other kinds need the read bit. A missing bit gives `rsp_fault_o`=1.
- R8: A fetch (kind 2) from a region with the execute-never bit set faults, even when the read bit allows it.
- R9: An address no enabled region hits gives `rsp_hit_o`=0 and `rsp_region_o`=0. A privileged access then gets no fault, with normal, non-shareable attributes. An unprivileged access faults.
- R10: `rsp_mem_type_o` reports 0 strongly ordered, 1 device, 2 normal, 3 reserved. The type is decoded from {TEX,C,B} as follows:
  - 000,00 gives 0.
  - 000,01 gives 1.
  - 000,1x gives 2.
  - 001,00 and 001,11 give 2.
  - 001,01 and 001,10 give 3.
  - 010,00 gives 1.
  - 010 with C or B set gives 3.
  - Any TEX of 011 or above gives 3.
- R11: For normal memory the shareable output equals the S bit. TEX=000 strongly ordered and device memory are shareable. TEX=010 device memory is not shareable.
- R12: For reserved encodings `rsp_reserved_o`=1, the type is 3 and shareable is 0. The fault flag is still computed from the permissions alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store a region descriptor |
| wr_idx_i | input | 3 | Region index to store |
| wr_enable_i | input | 1 | Region enable |
| wr_base_i | input | 32 | Region base address |
| wr_size_i | input | 5 | Size code N, span 2^(N+1) bytes |
| wr_srd_i | input | 8 | Slice disable mask |
| wr_ap_i | input | 4 | Permission bits {uw,ur,pw,pr} |
| wr_xn_i | input | 1 | Execute-never |
| wr_tex_i | input | 3 | TEX attribute |
| wr_s_i | input | 1 | Shareable attribute |
| wr_c_i | input | 1 | C attribute |
| wr_b_i | input | 1 | B attribute |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | Lookup address |
| req_acc_i | input | 2 | Access kind 0 rd, 1 wr, 2 fetch, 3 rd |
| req_priv_i | input | 1 | Privileged access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Some enabled region hit |
| rsp_region_o | output | 3 | Winning region index |
| rsp_fault_o | output | 1 | Permission fault |
| rsp_mem_type_o | output | 2 | Memory type code |
| rsp_shareable_o | output | 1 | Shareable |
| rsp_reserved_o | output | 1 | Reserved attribute encoding |

## Verification
A descriptor write and a lookup can land in the same cycle, and the write may even rewrite the region the lookup is about to select. The bench provokes this in a directed step: it disables a region while it looks up an address inside that region, and then repeats the lookup one cycle later. The random phase issues writes to random indices alongside most lookups. Its model computes each expected response from the region table as it stood before that cycle's write, and only then applies the write. Any early or late visibility of new contents therefore shows up as a mismatch in the hit, region or fault fields.

// File: rtl/mpu_pkg.sv
`timescale 1ns/1ps
package mpu_pkg;
  localparam int ADDR_W   = 32;
  localparam int SIZE_W   = 5;
  localparam int SUB_N    = 8;
  localparam int SUB_MIN  = 7;   // size code from which slice masking applies

  typedef enum logic [1:0] {
    MT_SO   = 2'd0,
    MT_DEV  = 2'd1,
    MT_NORM = 2'd2,
    MT_RSVD = 2'd3
  } mem_type_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RD2 = 2'd3
  } acc_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic [SUB_N-1:0]  srd;
    logic [3:0]        ap;
    logic              xn;
    logic [2:0]        tex;
    logic              s;
    logic              c;
    logic              b;
  } region_t;
endpackage

// File: rtl/mpu_region_file.sv
`timescale 1ns/1ps
module mpu_region_file
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_valid_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  region_t                     wr_cfg_i,
  output region_t [NUM_REGIONS-1:0]   regions_o
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regions_o[g] <= '0;
      end else if (wr_valid_i && wr_idx_i == IDX_W'(g)) begin
        regions_o[g] <= wr_cfg_i;
      end
    end
  end

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> regions_o[$past(wr_idx_i)] == $past(wr_cfg_i));

endmodule

// File: rtl/mpu_region_match.sv
`timescale 1ns/1ps
module mpu_region_match
  import mpu_pkg::*;
(
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SUB_N-1:0]  srd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int PW_W = SIZE_W + 1;

  logic [PW_W-1:0]   pw;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] mask;
  logic [2:0]        sub_idx;
  logic              in_span;
  logic              sub_on;

  always_comb begin
    pw      = {1'b0, size_i} + PW_W'(1);
    span    = ADDR_W'(1) << pw;          // zero when span is the full space
    mask    = ~(span - ADDR_W'(1));
    in_span = (addr_i & mask) == (base_i & mask);
    sub_idx = 3'(addr_i >> (pw - PW_W'(3)));
    sub_on  = (size_i >= SIZE_W'(SUB_MIN)) && srd_i[sub_idx];
    hit_o   = en_i && in_span && !sub_on;
  end
endmodule

// File: rtl/mpu_attr_decode.sv
`timescale 1ns/1ps
module mpu_attr_decode
  import mpu_pkg::*;
(
  input  logic [2:0] tex_i,
  input  logic       s_i,
  input  logic       c_i,
  input  logic       b_i,
  output mem_type_e  mem_type_o,
  output logic       shareable_o,
  output logic       reserved_o
);
  always_comb begin
    mem_type_o  = MT_RSVD;
    shareable_o = 1'b0;
    unique case (tex_i)
      3'b000: begin
        case ({c_i, b_i})
          2'b00:   begin mem_type_o = MT_SO;   shareable_o = 1'b1; end
          2'b01:   begin mem_type_o = MT_DEV;  shareable_o = 1'b1; end
          default: begin mem_type_o = MT_NORM; shareable_o = s_i;  end
        endcase
      end
      3'b001: begin
        if (c_i == b_i) begin
          mem_type_o  = MT_NORM;
          shareable_o = s_i;
        end
      end
      3'b010: begin
        if (!c_i && !b_i) mem_type_o = MT_DEV;   // non-shared device
      end
      default: ;
    endcase
    reserved_o = (mem_type_o == MT_RSVD);
  end
endmodule

// File: rtl/mpu_lookup.sv
`timescale 1ns/1ps
module mpu_lookup
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_enable_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [SUB_N-1:0]  wr_srd_i,
  input  logic [3:0]        wr_ap_i,
  input  logic              wr_xn_i,
  input  logic [2:0]        wr_tex_i,
  input  logic              wr_s_i,
  input  logic              wr_c_i,
  input  logic              wr_b_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_priv_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_region_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_mem_type_o,
  output logic              rsp_shareable_o,
  output logic              rsp_reserved_o
);

  region_t                   wr_cfg;
  region_t [NUM_REGIONS-1:0] regions;
  logic    [NUM_REGIONS-1:0] hit;

  assign wr_cfg = '{en: wr_enable_i, base: wr_base_i, size: wr_size_i, srd: wr_srd_i,
                    ap: wr_ap_i, xn: wr_xn_i, tex: wr_tex_i, s: wr_s_i, c: wr_c_i, b: wr_b_i};

  mpu_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_idx_i   (wr_idx_i),
    .wr_cfg_i   (wr_cfg),
    .regions_o  (regions)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mpu_region_match u_match (
      .en_i   (regions[g].en),
      .base_i (regions[g].base),
      .size_i (regions[g].size),
      .srd_i  (regions[g].srd),
      .addr_i (req_addr_i),
      .hit_o  (hit[g])
    );
  end

  // highest index wins
  logic [IDX_W-1:0] win_idx;
  logic             any_hit;
  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  mem_type_e dec_type;
  logic      dec_share;
  logic      dec_rsvd;

  mpu_attr_decode u_attr (
    .tex_i       (regions[win_idx].tex),
    .s_i         (regions[win_idx].s),
    .c_i         (regions[win_idx].c),
    .b_i         (regions[win_idx].b),
    .mem_type_o  (dec_type),
    .shareable_o (dec_share),
    .reserved_o  (dec_rsvd)
  );

  logic      is_wr, is_ex, perm_ok, fault_d;
  mem_type_e type_d;
  logic      share_d, rsvd_d;

  always_comb begin
    is_wr   = (req_acc_i == ACC_WR);
    is_ex   = (req_acc_i == ACC_EX);
    if (req_priv_i) perm_ok = is_wr ? regions[win_idx].ap[1] : regions[win_idx].ap[0];
    else            perm_ok = is_wr ? regions[win_idx].ap[3] : regions[win_idx].ap[2];
    if (any_hit) begin
      fault_d = (is_ex && regions[win_idx].xn) || !perm_ok;
      type_d  = dec_type;
      share_d = dec_share;
      rsvd_d  = dec_rsvd;
    end else begin
      fault_d = !req_priv_i;   // background map
      type_d  = MT_NORM;
      share_d = 1'b0;
      rsvd_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_hit_o       <= 1'b0;
      rsp_region_o    <= '0;
      rsp_fault_o     <= 1'b0;
      rsp_mem_type_o  <= 2'd0;
      rsp_shareable_o <= 1'b0;
      rsp_reserved_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o       <= any_hit;
        rsp_region_o    <= win_idx;
        rsp_fault_o     <= fault_d;
        rsp_mem_type_o  <= type_d;
        rsp_shareable_o <= share_d;
        rsp_reserved_o  <= rsvd_d;
      end
    end
  end

  p_valid_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_winner_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && any_hit) |-> regions[win_idx].en);
  p_xn_fetch_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && any_hit && regions[win_idx].xn && req_acc_i == ACC_EX) |=> rsp_fault_o);
  p_user_miss_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !any_hit && !req_priv_i) |=> (rsp_fault_o && !rsp_hit_o));
  p_reserved_type_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_reserved_o |-> (rsp_mem_type_o == MT_RSVD && !rsp_shareable_o));

endmodule

// File: tb/tb_mpu_lookup.sv
`timescale 1ns/1ps
module tb_mpu_lookup;
  localparam int NR = 8;
  localparam logic [31:0] B = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_valid_i = 0;
  logic [2:0]  wr_idx_i = 0;
  logic        wr_enable_i = 0;
  logic [31:0] wr_base_i = 0;
  logic [4:0]  wr_size_i = 0;
  logic [7:0]  wr_srd_i = 0;
  logic [3:0]  wr_ap_i = 0;
  logic        wr_xn_i = 0;
  logic [2:0]  wr_tex_i = 0;
  logic        wr_s_i = 0, wr_c_i = 0, wr_b_i = 0;
  logic        req_valid_i = 0;
  logic [31:0] req_addr_i = 0;
  logic [1:0]  req_acc_i = 0;
  logic        req_priv_i = 0;
  logic        rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_shareable_o, rsp_reserved_o;
  logic [2:0]  rsp_region_o;
  logic [1:0]  rsp_mem_type_o;

  mpu_lookup dut (.*, .clk_i(clk));

  int checks = 0;
  int errors = 0;

  // bench model of the region table
  logic        m_en[NR];
  logic [31:0] m_base[NR];
  logic [4:0]  m_size[NR];
  logic [7:0]  m_srd[NR];
  logic [3:0]  m_ap[NR];
  logic        m_xn[NR];
  logic [2:0]  m_tex[NR];
  logic        m_s[NR], m_c[NR], m_b[NR];

  logic       e_hit, e_fault, e_sh, e_res;
  logic [2:0] e_reg;
  logic [1:0] e_type;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_match(int r, logic [31:0] a);
    logic [32:0] span, lo, off;
    int sub;
    if (!m_en[r]) return 1'b0;
    span = 33'h1 << (int'(m_size[r]) + 1);
    lo   = {1'b0, m_base[r]} & ~(span - 33'h1);
    if ({1'b0, a} < lo) return 1'b0;
    off = {1'b0, a} - lo;
    if (off >= span) return 1'b0;
    if (m_size[r] >= 5'd7) begin
      sub = int'(off / (span >> 3));
      if (m_srd[r][sub]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic model_eval(logic [31:0] a, logic [1:0] acc, logic priv);
    int w = -1;
    logic ok;
    for (int r = 0; r < NR; r++) if (m_match(r, a)) w = r;
    if (w < 0) begin
      e_hit = 0; e_reg = 0; e_fault = !priv; e_type = 2; e_sh = 0; e_res = 0;
      return;
    end
    e_hit = 1; e_reg = 3'(w);
    ok = priv ? ((acc == 2'd1) ? m_ap[w][1] : m_ap[w][0])
              : ((acc == 2'd1) ? m_ap[w][3] : m_ap[w][2]);
    e_fault = !ok || (acc == 2'd2 && m_xn[w]);
    e_type = 3; e_sh = 0;
    case (m_tex[w])
      3'd0: if (!m_c[w] && !m_b[w]) begin e_type = 0; e_sh = 1; end
            else if (!m_c[w])       begin e_type = 1; e_sh = 1; end
            else                    begin e_type = 2; e_sh = m_s[w]; end
      3'd1: if (m_c[w] == m_b[w]) begin e_type = 2; e_sh = m_s[w]; end
      3'd2: if (!m_c[w] && !m_b[w]) e_type = 1;
      default: ;
    endcase
    e_res = (e_type == 3);
  endtask

  task automatic model_write();
    m_en[wr_idx_i] = wr_enable_i;  m_base[wr_idx_i] = wr_base_i;
    m_size[wr_idx_i] = wr_size_i;  m_srd[wr_idx_i] = wr_srd_i;
    m_ap[wr_idx_i] = wr_ap_i;      m_xn[wr_idx_i] = wr_xn_i;
    m_tex[wr_idx_i] = wr_tex_i;    m_s[wr_idx_i] = wr_s_i;
    m_c[wr_idx_i] = wr_c_i;        m_b[wr_idx_i] = wr_b_i;
  endtask

  // one clock: expected from pre-write table, then write lands, then sample
  task automatic tick();
    logic ev = req_valid_i;
    if (ev) model_eval(req_addr_i, req_acc_i, req_priv_i);
    if (wr_valid_i) model_write();
    @(posedge clk); #1;
    chk("R3", "valid", rsp_valid_o, ev);
    if (ev) begin
      chk("R6", "hit", rsp_hit_o, e_hit);
      chk("R6", "region", rsp_region_o, e_reg);
      chk("R7", "fault", rsp_fault_o, e_fault);
      chk("R10", "type", rsp_mem_type_o, e_type);
      chk("R11", "share", rsp_shareable_o, e_sh);
      chk("R12", "reserved", rsp_reserved_o, e_res);
    end
  endtask

  task automatic prog(int idx, logic en, logic [31:0] base, logic [4:0] sz, logic [7:0] srd,
                      logic [3:0] ap, logic xn, logic [2:0] tex, logic s, logic c, logic b);
    wr_valid_i = 1; wr_idx_i = 3'(idx); wr_enable_i = en; wr_base_i = base;
    wr_size_i = sz; wr_srd_i = srd; wr_ap_i = ap; wr_xn_i = xn; wr_tex_i = tex;
    wr_s_i = s; wr_c_i = c; wr_b_i = b;
    req_valid_i = 0;
    tick();
    wr_valid_i = 0;
  endtask

  task automatic look(logic [31:0] a, logic [1:0] acc, logic priv);
    req_valid_i = 1; req_addr_i = a; req_acc_i = acc; req_priv_i = priv;
    tick();
    req_valid_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin
      m_en[r] = 0; m_base[r] = 0; m_size[r] = 0; m_srd[r] = 0; m_ap[r] = 0;
      m_xn[r] = 0; m_tex[r] = 0; m_s[r] = 0; m_c[r] = 0; m_b[r] = 0;
    end
    #12;
    chk("R1", "valid in reset", rsp_valid_o, 0);
    chk("R1", "fault in reset", rsp_fault_o, 0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #1;

    look(B, 2'd0, 1'b0);
    chk("R1", "unprogrammed hit", rsp_hit_o, 0);
    chk("R1", "unprogrammed user fault", rsp_fault_o, 1);

    // 128 KB normal region 1 and 512 KB device region 6 on one base, low two slices off
    prog(1, 1, B, 5'd16, 8'h00, 4'hF, 0, 3'd0, 0, 1, 0);
    prog(6, 1, B, 5'd18, 8'h03, 4'h5, 1, 3'd0, 0, 0, 1);
    look(B + 32'h1_1800, 2'd0, 1'b1);
    chk("R5", "masked slice falls through", rsp_region_o, 1);
    look(B + 32'h2_0800, 2'd0, 1'b1);
    chk("R6", "upper slice to region 6", rsp_region_o, 6);
    chk("R11", "device shareable", rsp_shareable_o, 1);
    look(B + 32'h0_8000, 2'd1, 1'b0);
    chk("R7", "user write allowed", rsp_fault_o, 0);
    look(B + 32'h4_0000, 2'd1, 1'b1);
    chk("R7", "write denied", rsp_fault_o, 1);
    look(B + 32'h4_0000, 2'd2, 1'b1);
    chk("R8", "fetch execute-never", rsp_fault_o, 1);
    look(B + 32'h0_0100, 2'd2, 1'b1);
    chk("R8", "fetch allowed", rsp_fault_o, 0);
    look(B + 32'h8_0000, 2'd0, 1'b1);
    chk("R9", "priv miss no fault", rsp_fault_o, 0);
    chk("R9", "priv miss type", rsp_mem_type_o, 2);
    look(B + 32'h8_0000, 2'd0, 1'b0);
    chk("R9", "user miss fault", rsp_fault_o, 1);

    // alignment and small-region slice mask
    prog(3, 1, 32'h3000_0123, 5'd7, 8'h00, 4'hF, 0, 3'd1, 1, 1, 1);
    look(32'h3000_0100, 2'd0, 1'b0);
    chk("R4", "aligned low edge", rsp_hit_o, 1);
    look(32'h3000_01FF, 2'd0, 1'b0);
    chk("R4", "aligned high edge", rsp_region_o, 3);
    look(32'h3000_0200, 2'd0, 1'b1);
    chk("R4", "past span", rsp_hit_o, 0);
    prog(4, 1, 32'h3000_0400, 5'd5, 8'hFF, 4'hF, 0, 3'd0, 0, 1, 1);
    look(32'h3000_0410, 2'd0, 1'b1);
    chk("R5", "mask ignored small", rsp_region_o, 4);
    prog(5, 1, 32'h3000_1000, 5'd7, 8'h80, 4'hF, 0, 3'd0, 0, 0, 0);
    look(32'h3000_10E0, 2'd0, 1'b1);
    chk("R5", "top slice off", rsp_hit_o, 0);
    look(32'h3000_10DF, 2'd0, 1'b1);
    chk("R5", "slice 6 on", rsp_hit_o, 1);
    chk("R10", "strongly ordered", rsp_mem_type_o, 0);

    // reserved encoding, then disable it while looking it up
    prog(2, 1, 32'h4000_0000, 5'd10, 8'h00, 4'hF, 0, 3'd1, 1, 1, 0);
    look(32'h4000_0000, 2'd0, 1'b1);
    chk("R12", "reserved flag", rsp_reserved_o, 1);
    wr_valid_i = 1; wr_idx_i = 2; wr_enable_i = 0;
    req_valid_i = 1; req_addr_i = 32'h4000_0000; req_acc_i = 0; req_priv_i = 1;
    tick();
    chk("R2", "same-cycle lookup sees old", rsp_hit_o, 1);
    wr_valid_i = 0;
    tick();
    chk("R2", "next lookup sees new", rsp_hit_o, 0);
    req_valid_i = 0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      wr_valid_i = ($urandom % 4) == 0;
      wr_idx_i = 3'($urandom);
      wr_enable_i = ($urandom % 4) != 0;
      wr_base_i = B + ($urandom & 32'h000F_FF00);
      wr_size_i = 5'(7 + $urandom % 12);
      wr_srd_i = 8'($urandom);
      wr_ap_i = 4'($urandom);
      wr_xn_i = 1'($urandom);
      wr_tex_i = 3'($urandom % 4);
      {wr_s_i, wr_c_i, wr_b_i} = 3'($urandom);
      req_valid_i = ($urandom % 4) != 0;
      req_addr_i = (($urandom % 8) == 0) ? $urandom : B + ($urandom % 32'h0010_0000);
      req_acc_i = 2'($urandom);
      req_priv_i = 1'($urandom);
      tick();
    end
    wr_valid_i = 0; req_valid_i = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule